// File: doc/BRIEF.md
# Receive Destination Address Screen

This block decides, for every incoming frame, whether its destination MAC address is wanted by the station, and classifies accepted addresses as multicast or broadcast. It keeps a small content-addressable table of station addresses, each entry gated by one bit of an enable mask, and combines table hits with three mode switches: a promiscuous switch, an accept-every-multicast switch and an accept-broadcast switch. These classes are tested in a fixed priority order, so the class flag is deterministic when several apply.

A request is a 48-bit address with a valid strobe. One clock later the block returns a registered verdict: either an accept pulse together with a 16-bit status word carrying the class flags, or a reject pulse with an empty status word. Software or a loader fills the table through a sequential load port with an auto-advancing entry pointer and sets the enable mask separately. While the controller is held in reset, any entry can be read back through a window of three 16-bit ports.

Address layout used throughout: byte k of an address occupies bits [8k+7:8k], byte 0 is the first byte on the wire, and bit 0 (the low bit of byte 0) is the group bit that marks a multicast address.

Top module: `rx_addr_screen`

## Requirements
- R1: Each cycle with `req_valid` high produces `res_valid` high exactly one cycle later with the verdict for that address; in a cycle following no request, `res_valid`, `res_accept`, `res_reject` and `res_status` are all zero.
- R2: When `mode_promisc` is high and the address group bit (bit 0) is clear, the address is accepted with `res_status` equal to zero, whatever the table holds.
- R3: Otherwise, when `mode_all_mcast` is high and the group bit is set, the address is accepted with only the multicast flag, `res_status` bit 8 (0x0100), set; this wins over the broadcast class.
- R4: Otherwise, when `mode_bcast` is high and all 48 address bits are one, the address is accepted with only the broadcast flag, `res_status` bit 7 (0x0080), set.
- R5: Otherwise, the address is accepted with `res_status` equal to zero if it equals the contents of any table entry whose enable-mask bit is set; entries with a clear mask bit never match.
- R6: An address accepted by none of R2 to R5 yields a `res_reject` pulse with `res_status` zero; `res_accept` and `res_reject` are never high together and exactly one of them is high with `res_valid`.
- R7: A cycle with `load_valid` writes `load_data` (same byte layout as the address, so `load_data[15:0]` holds byte 1 in the upper half and byte 0 in the lower half) to the entry at the load pointer and then advances the pointer by one, wrapping from 15 to 0; `load_start` sets the pointer to `load_index` first, taking effect in the same cycle.
- R8: `mask_load` replaces the 16-bit enable mask with `mask_data` (bit e enables entry e); after reset the mask, the table contents and the load pointer are all zero.
- R9: With `ctl_reset` high, `rd_lo`, `rd_mid` and `rd_hi` show bytes 1:0, 3:2 and 5:4 of entry `rd_entry`, the higher-numbered byte in the upper half; with `ctl_reset` low all three read zero.
- R10: A lookup issued in the same cycle as a table write or a mask load is judged against the table and mask as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 48 | Destination address to screen |
| mode_promisc | input | 1 | Accept every unicast address |
| mode_all_mcast | input | 1 | Accept every group address |
| mode_bcast | input | 1 | Accept the all-ones address |
| load_valid | input | 1 | Write one table entry |
| load_start | input | 1 | Set the load pointer from load_index |
| load_index | input | 4 | Starting entry for a load sequence |
| load_data | input | 48 | Entry contents |
| mask_load | input | 1 | Replace the enable mask |
| mask_data | input | 16 | New enable mask |
| ctl_reset | input | 1 | Controller held in reset; opens the readback window |
| rd_entry | input | 4 | Entry selected for readback |
| res_valid | output | 1 | Verdict valid, one cycle after req_valid |
| res_accept | output | 1 | Address accepted |
| res_reject | output | 1 | Address rejected |
| res_status | output | 16 | Class flags: bit 8 multicast, bit 7 broadcast |
| rd_lo | output | 16 | Entry bytes 1:0 |
| rd_mid | output | 16 | Entry bytes 3:2 |
| rd_hi | output | 16 | Entry bytes 5:4 |

## Verification
The two functions that can coincide are a lookup and an update of the state it reads: a table write to the very entry being looked up, or a mask load that removes that entry's enable bit, on the same clock edge as the request. The bench drives both on one edge and expects the verdict of the old contents, then repeats the lookup on the next request and expects the verdict of the new contents. Around this, sweeps over every entry against many masks and over all eight mode combinations against unicast, miss, multicast and broadcast addresses check the priority order and class flags against a model computed in the bench.

// File: rtl/addr_screen_pkg.sv
package addr_screen_pkg;

  localparam int unsigned STATUS_W  = 16;
  localparam int unsigned ST_MC_BIT = 8;
  localparam int unsigned ST_BC_BIT = 7;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } addr_class_e;

  function automatic logic [STATUS_W-1:0] class_status(input addr_class_e cls);
    logic [STATUS_W-1:0] w;
    w = '0;
    w[ST_MC_BIT] = (cls == CLS_MCAST);
    w[ST_BC_BIT] = (cls == CLS_BCAST);
    return w;
  endfunction

endpackage

// File: rtl/addr_cam_store.sv
module addr_cam_store #(
  parameter  int N_ENTRIES = 16,
  parameter  int WORD_W    = 16,
  localparam int MAC_W     = 3 * WORD_W,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic             load_start,
  input  logic [IDX_W-1:0] load_index,
  input  logic [MAC_W-1:0] load_data,
  input  logic             mask_load,
  input  logic [N_ENTRIES-1:0] mask_data,
  input  logic             rd_open,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [MAC_W-1:0] tab_q [N_ENTRIES],
  output logic [N_ENTRIES-1:0] mask_q,
  output logic [WORD_W-1:0] rd_lo,
  output logic [WORD_W-1:0] rd_mid,
  output logic [WORD_W-1:0] rd_hi
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] wr_ptr_q, wr_ptr_d, wr_idx;
  logic [N_ENTRIES-1:0] mask_d;
  logic [MAC_W-1:0] rd_word;

  // pointer next-state: start overrides, write advances with wrap
  always_comb begin
    wr_idx   = load_start ? load_index : wr_ptr_q;
    wr_ptr_d = wr_ptr_q;
    if (load_valid) begin
      wr_ptr_d = (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
    end else if (load_start) begin
      wr_ptr_d = load_index;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_load) mask_d = mask_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      mask_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      mask_q   <= mask_d;
    end
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    logic wr_en;
    assign wr_en = load_valid && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tab_q[e] <= '0;
      end else if (wr_en) begin
        tab_q[e] <= load_data;
      end
    end
  end

  // readback window, closed unless the controller is held in reset
  always_comb begin
    rd_word = rd_open ? tab_q[rd_sel] : '0;
    rd_lo   = rd_word[WORD_W-1:0];
    rd_mid  = rd_word[2*WORD_W-1:WORD_W];
    rd_hi   = rd_word[3*WORD_W-1:2*WORD_W];
  end

endmodule

// File: rtl/addr_cam_match.sv
module addr_cam_match #(
  parameter  int N_ENTRIES = 16,
  parameter  int WORD_W    = 16,
  localparam int MAC_W     = 3 * WORD_W
) (
  input  logic [MAC_W-1:0]     addr,
  input  logic [MAC_W-1:0]     tab_q [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] mask_q,
  output logic                 any_hit
);

  logic [N_ENTRIES-1:0] hit;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign hit[e] = mask_q[e] && (tab_q[e] == addr);
  end

  assign any_hit = |hit;

endmodule

// File: rtl/addr_screen_decide.sv
module addr_screen_decide
  import addr_screen_pkg::*;
#(
  parameter  int WORD_W = 16,
  localparam int MAC_W  = 3 * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [MAC_W-1:0]    req_addr,
  input  logic                mode_promisc,
  input  logic                mode_all_mcast,
  input  logic                mode_bcast,
  input  logic                any_hit,
  output logic                res_valid,
  output logic                res_accept,
  output logic                res_reject,
  output logic [STATUS_W-1:0] res_status
);

  addr_class_e cls_d, cls_q;
  logic        acc_raw, acc_d, rej_d, acc_q, rej_q, vld_q;
  logic        is_group, is_bcast;

  assign is_group = req_addr[0];
  assign is_bcast = &req_addr;

  // fixed priority: promiscuous unicast, all-multicast, broadcast, table
  always_comb begin
    acc_raw = 1'b0;
    cls_d   = CLS_NONE;
    if (mode_promisc && !is_group) begin
      acc_raw = 1'b1;
    end else if (mode_all_mcast && is_group) begin
      acc_raw = 1'b1;
      cls_d   = CLS_MCAST;
    end else if (mode_bcast && is_bcast) begin
      acc_raw = 1'b1;
      cls_d   = CLS_BCAST;
    end else if (any_hit) begin
      acc_raw = 1'b1;
    end
    acc_d = req_valid && acc_raw;
    rej_d = req_valid && !acc_raw;
    if (!req_valid) cls_d = CLS_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      rej_q <= 1'b0;
      cls_q <= CLS_NONE;
    end else begin
      vld_q <= req_valid;
      acc_q <= acc_d;
      rej_q <= rej_d;
      cls_q <= cls_d;
    end
  end

  assign res_valid  = vld_q;
  assign res_accept = acc_q;
  assign res_reject = rej_q;
  assign res_status = class_status(cls_q);

endmodule

// File: rtl/rx_addr_screen.sv
module rx_addr_screen
  import addr_screen_pkg::*;
#(
  parameter  int N_ENTRIES = 16,
  parameter  int WORD_W    = 16,
  localparam int MAC_W     = 3 * WORD_W,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [MAC_W-1:0]     req_addr,
  input  logic                 mode_promisc,
  input  logic                 mode_all_mcast,
  input  logic                 mode_bcast,
  input  logic                 load_valid,
  input  logic                 load_start,
  input  logic [IDX_W-1:0]     load_index,
  input  logic [MAC_W-1:0]     load_data,
  input  logic                 mask_load,
  input  logic [N_ENTRIES-1:0] mask_data,
  input  logic                 ctl_reset,
  input  logic [IDX_W-1:0]     rd_entry,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic                 res_reject,
  output logic [STATUS_W-1:0]  res_status,
  output logic [WORD_W-1:0]    rd_lo,
  output logic [WORD_W-1:0]    rd_mid,
  output logic [WORD_W-1:0]    rd_hi
);

  logic [MAC_W-1:0]     tab_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] mask_q;
  logic                 any_hit;

  addr_cam_store #(.N_ENTRIES(N_ENTRIES), .WORD_W(WORD_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_start (load_start),
    .load_index (load_index),
    .load_data  (load_data),
    .mask_load  (mask_load),
    .mask_data  (mask_data),
    .rd_open    (ctl_reset),
    .rd_sel     (rd_entry),
    .tab_q      (tab_q),
    .mask_q     (mask_q),
    .rd_lo      (rd_lo),
    .rd_mid     (rd_mid),
    .rd_hi      (rd_hi)
  );

  addr_cam_match #(.N_ENTRIES(N_ENTRIES), .WORD_W(WORD_W)) u_match (
    .addr    (req_addr),
    .tab_q   (tab_q),
    .mask_q  (mask_q),
    .any_hit (any_hit)
  );

  addr_screen_decide #(.WORD_W(WORD_W)) u_decide (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .mode_promisc   (mode_promisc),
    .mode_all_mcast (mode_all_mcast),
    .mode_bcast     (mode_bcast),
    .any_hit        (any_hit),
    .res_valid      (res_valid),
    .res_accept     (res_accept),
    .res_reject     (res_reject),
    .res_status     (res_status)
  );

endmodule

// File: rtl/rx_addr_screen_chk.sv
module rx_addr_screen_chk
  import addr_screen_pkg::*;
#(
  parameter  int WORD_W = 16,
  localparam int MAC_W  = 3 * WORD_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [MAC_W-1:0]    req_addr,
  input logic                mode_promisc,
  input logic                mode_all_mcast,
  input logic                mode_bcast,
  input logic                ctl_reset,
  input logic                res_valid,
  input logic                res_accept,
  input logic                res_reject,
  input logic [STATUS_W-1:0] res_status,
  input logic [WORD_W-1:0]   rd_lo,
  input logic [WORD_W-1:0]   rd_mid,
  input logic [WORD_W-1:0]   rd_hi
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !res_accept && !res_reject && res_status == '0));

  a_r2_promisc_unicast: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_promisc && !req_addr[0]) |=> (res_accept && res_status == '0));

  a_r3_mcast_source: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[ST_MC_BIT] |-> ($past(req_addr[0]) && $past(mode_all_mcast) && res_accept));

  a_r4_bcast_source: assert property (@(posedge clk) disable iff (!rst_n)
    res_status[ST_BC_BIT] |-> ($past(&req_addr) && $past(mode_bcast)
                               && !$past(mode_all_mcast) && res_accept));

  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_accept ^ res_reject));

  a_r6_reject_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    res_reject |-> (res_status == '0));

  a_r9_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_reset |-> (rd_lo == '0 && rd_mid == '0 && rd_hi == '0));

endmodule

bind rx_addr_screen rx_addr_screen_chk #(.WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .mode_promisc   (mode_promisc),
  .mode_all_mcast (mode_all_mcast),
  .mode_bcast     (mode_bcast),
  .ctl_reset      (ctl_reset),
  .res_valid      (res_valid),
  .res_accept     (res_accept),
  .res_reject     (res_reject),
  .res_status     (res_status),
  .rd_lo          (rd_lo),
  .rd_mid         (rd_mid),
  .rd_hi          (rd_hi)
);

// File: tb/test_rx_addr_screen.sv
`timescale 1ns/1ps
module test_rx_addr_screen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_addr = '0;
  logic        mode_promisc = 1'b0, mode_all_mcast = 1'b0, mode_bcast = 1'b0;
  logic        load_valid = 1'b0, load_start = 1'b0;
  logic [3:0]  load_index = '0;
  logic [47:0] load_data = '0;
  logic        mask_load = 1'b0;
  logic [15:0] mask_data = '0;
  logic        ctl_reset = 1'b0;
  logic [3:0]  rd_entry = '0;
  logic        res_valid, res_accept, res_reject;
  logic [15:0] res_status, rd_lo, rd_mid, rd_hi;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [47:0] m_tab [16];
  logic [15:0] m_mask;
  int          m_ptr;

  always #10 clk = ~clk;

  rx_addr_screen i_rx_addr_screen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast), .mode_bcast(mode_bcast),
    .load_valid(load_valid), .load_start(load_start), .load_index(load_index),
    .load_data(load_data), .mask_load(mask_load), .mask_data(mask_data),
    .ctl_reset(ctl_reset), .rd_entry(rd_entry),
    .res_valid(res_valid), .res_accept(res_accept), .res_reject(res_reject),
    .res_status(res_status), .rd_lo(rd_lo), .rd_mid(rd_mid), .rd_hi(rd_hi)
  );

  function automatic logic [47:0] ent(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {8'h60, b, 8'h44, b ^ 8'h33, 8'h22, 8'h02 + 8'(i * 4)};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // expected verdict {valid, accept, reject, status} from the requirements
  function automatic logic [18:0] expect_v(input logic [47:0] a, input logic [2:0] md);
    logic hit;
    hit = 1'b0;
    for (int e = 0; e < 16; e++) if (m_mask[e] && m_tab[e] == a) hit = 1'b1;
    if (md[0] && !a[0])       return {1'b1, 1'b1, 1'b0, 16'h0000};
    else if (md[1] && a[0])   return {1'b1, 1'b1, 1'b0, 16'h0100};
    else if (md[2] && &a)     return {1'b1, 1'b1, 1'b0, 16'h0080};
    else if (hit)             return {1'b1, 1'b1, 1'b0, 16'h0000};
    else                      return {1'b1, 1'b0, 1'b1, 16'h0000};
  endfunction

  // md: bit0 promiscuous, bit1 all-multicast, bit2 broadcast
  task automatic lookup(input logic [47:0] a, input logic [2:0] md, input string req);
    logic [18:0] exp;
    exp = expect_v(a, md);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    {mode_bcast, mode_all_mcast, mode_promisc} = md;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {13'd0, res_valid, res_accept, res_reject, res_status}, {13'd0, exp});
  endtask

  task automatic load_one(input bit st, input int idx, input logic [47:0] d);
    int p;
    @(negedge clk);
    load_valid = 1'b1; load_start = st; load_index = 4'(idx); load_data = d;
    p = st ? idx : m_ptr;
    m_tab[p] = d;
    m_ptr = (p + 1) % 16;
    @(negedge clk);
    load_valid = 1'b0; load_start = 1'b0;
  endtask

  task automatic set_mask(input logic [15:0] m);
    @(negedge clk);
    mask_load = 1'b1; mask_data = m;
    m_mask = m;
    @(negedge clk);
    mask_load = 1'b0;
  endtask

  task automatic readback(input int i, input string req);
    @(negedge clk);
    rd_entry = 4'(i);
    #1;
    if (ctl_reset) begin
      check(req, {16'd0, rd_lo},  {16'd0, m_tab[i][15:0]});
      check(req, {16'd0, rd_mid}, {16'd0, m_tab[i][31:16]});
      check(req, {16'd0, rd_hi},  {16'd0, m_tab[i][47:32]});
    end else begin
      check(req, {rd_hi, rd_lo}, 32'd0);
      check(req, {16'd0, rd_mid}, 32'd0);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 16; e++) m_tab[e] = '0;
    m_mask = '0;
    m_ptr  = 0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check("R1 reset", {29'd0, res_valid, res_accept, res_reject}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", {16'd0, res_status}, 32'd0);

    // R8: reset table zero and mask empty, so the zero address misses
    ctl_reset = 1'b1;
    readback(0, "R8 reset table");
    readback(9, "R8 reset table");
    lookup(48'h0, 3'b000, "R8 reset mask");

    // R7: sequential load of all entries from index 0
    load_one(1'b1, 0, ent(0));
    for (int e = 1; e < 16; e++) load_one(1'b0, 0, ent(e));
    for (int e = 0; e < 16; e++) readback(e, "R9 R7 readback");

    // R7: wrap from 15 to 0
    load_one(1'b1, 15, 48'hAAAA_5555_0C0C);
    load_one(1'b0, 3, 48'h1357_9BDF_0E0E);
    readback(15, "R7 wrap last");
    readback(0, "R7 wrap first");
    load_one(1'b1, 15, ent(15));
    load_one(1'b0, 0, ent(0));
    readback(15, "R7 restore");
    readback(0, "R7 restore");

    // R9: window closed outside controller reset
    ctl_reset = 1'b0;
    for (int e = 0; e < 16; e += 5) readback(e, "R9 closed");
    ctl_reset = 1'b1;

    // R5, R6: each entry against every one-hot mask, empty and full masks
    for (int m = 0; m < 18; m++) begin
      set_mask(m < 16 ? (16'h1 << m) : (m == 16 ? 16'h0000 : 16'hFFFF));
      for (int e = 0; e < 16; e++) lookup(ent(e), 3'b000, "R5 table match");
      lookup(48'h1234_5678_9A00, 3'b000, "R6 miss");
    end
    set_mask(16'hA5C3);
    for (int e = 0; e < 16; e++) lookup(ent(e), 3'b000, "R5 mixed mask");

    // R2, R3, R4: priority over all mode combinations and address classes
    set_mask(16'hFFFF);
    load_one(1'b1, 7, 48'hFFFF_FFFF_FFFF);
    load_one(1'b1, 8, 48'h0000_5E00_0001);
    for (int md = 0; md < 8; md++) begin
      lookup(ent(5), 3'(md), "R2 unicast hit");
      lookup(48'h1234_5678_9A00, 3'(md), "R2 unicast miss");
      lookup(48'h0000_5E00_0001, 3'(md), "R3 multicast in table");
      lookup(48'h0033_0000_0101, 3'(md), "R3 multicast miss");
      lookup(48'hFFFF_FFFF_FFFF, 3'(md), "R4 broadcast");
    end
    set_mask(16'hFE7F);
    for (int md = 0; md < 8; md++) lookup(48'hFFFF_FFFF_FFFF, 3'(md), "R4 broadcast no entry");
    load_one(1'b1, 7, ent(7));
    load_one(1'b1, 8, ent(8));
    set_mask(16'hFFFF);

    // R1: no result after an idle cycle
    @(negedge clk);
    @(negedge clk);
    check("R1 idle", {13'd0, res_valid, res_accept, res_reject, res_status}, 32'd0);

    // R10: lookup together with a write to the same entry
    begin
      logic [18:0] exp;
      exp = expect_v(ent(3), 3'b000);
      @(negedge clk);
      req_valid = 1'b1; req_addr = ent(3); {mode_bcast, mode_all_mcast, mode_promisc} = 3'b000;
      load_valid = 1'b1; load_start = 1'b1; load_index = 4'd3; load_data = 48'hBEEF_0000_0A0A;
      m_tab[3] = 48'hBEEF_0000_0A0A; m_ptr = 4;
      @(negedge clk);
      req_valid = 1'b0; load_valid = 1'b0; load_start = 1'b0;
      check("R10 write same cycle", {13'd0, res_valid, res_accept, res_reject, res_status}, {13'd0, exp});
    end
    lookup(ent(3), 3'b000, "R10 old contents gone");
    lookup(48'hBEEF_0000_0A0A, 3'b000, "R10 new contents");

    // R10: lookup together with a mask load that drops the entry
    begin
      logic [18:0] exp;
      exp = expect_v(ent(6), 3'b000);
      @(negedge clk);
      req_valid = 1'b1; req_addr = ent(6);
      mask_load = 1'b1; mask_data = 16'hFFBF;
      @(negedge clk);
      req_valid = 1'b0; mask_load = 1'b0;
      m_mask = 16'hFFBF;
      check("R10 mask same cycle", {13'd0, res_valid, res_accept, res_reject, res_status}, {13'd0, exp});
    end
    lookup(ent(6), 3'b000, "R10 mask applied");

    // R1: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_addr = ent(1);
    @(negedge clk);
    req_addr = 48'h1234_5678_9A00;
    check("R1 back-to-back first", {29'd0, res_valid, res_accept, res_reject}, {29'd0, 3'b110});
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 back-to-back second", {29'd0, res_valid, res_accept, res_reject}, {29'd0, 3'b101});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule